// File: doc/BRIEF.md
# 9-bit SPI Panel Command Engine

This block is a serial master for display panels whose control port speaks in 9-bit SPI words. The leading bit of every word is a flag: 0 marks a command, 1 marks a parameter. A client hands over one command byte, up to a fixed number of parameter bytes and a count of bytes to read back. The block then runs a complete transaction on the serial pins and raises a one-cycle completion pulse. When the pulse arrives, the received bytes sit in a parallel output buffer.

The transaction is a single chip-select window. The command word goes first, then the parameter words in buffer order, then the read phase. A read of one byte clocks eight bits in right after the last outgoing word. A longer read starts with a 9-clock word whose first bit is a dummy, then takes eight clocks for each further byte. The serial clock idles low and data-in is sampled on its rising edge (mode 0). Each half period lasts a parameterised number of system clock cycles.

Top module: `spi9_cmd_engine`

## Requirements
- R1: SCK is low whenever CS_N is high. MOSI changes only while SCK is low and is held steady through every high half. MISO is sampled at each SCK rising edge.
- R2: Each SCK high half and each low half lasts HALF_DIV system clock cycles.
- R3: The command goes out first as 9 bits: a 0 flag bit, then the command byte, most significant bit first.
- R4: Each parameter goes out as 9 bits: a 1 flag bit, then the byte, most significant bit first. Byte i comes from wr_data[8i+7:8i], and index 0 is sent first.
- R5: When the read count is one, exactly 8 clocks follow the last outgoing word. The 8 sampled bits, first sample as most significant bit, become rd_data[7:0].
- R6: When the read count N is above one, the first read word takes 9 clocks and its first sample is discarded. The remaining 8 samples form byte 0. Each further byte takes 8 clocks. Byte j lands in rd_data[8j+7:8j]. MOSI is 0 during all read clocks.
- R7: A count of zero skips its phase. The transaction therefore has exactly 9 + 9·W + (0 if N=0, 8 if N=1, 9+8·(N−1) otherwise) SCK pulses.
- R8: CS_N falls in the cycle after an accepted start and stays low through all words. It rises in the same cycle as done, and done lasts exactly one cycle. busy is high from the cycle after an accepted start until the cycle after done.
- R9: A parameter count above MAX_WR is treated as MAX_WR, and a read count above MAX_RD is treated as MAX_RD.
- R10: A start pulse while busy is high is ignored. No second transaction follows.
- R11: Every read-buffer byte at an index not filled by the current transaction reads 0 once done has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only while idle) |
| cmd_byte | input | 8 | Command byte, sampled with start |
| wr_count | input | CNT_W | Number of parameter bytes, sampled with start |
| wr_data | input | MAX_WR*8 | Parameter bytes, byte i at bits 8i+7:8i, sampled with start |
| rd_count | input | CNT_W | Number of bytes to read back, sampled with start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | MAX_RD*8 | Received bytes, byte j at bits 8j+7:8j |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_miso | input | 1 | Serial data from the panel |

## Verification
The bound checker watches several pin-level rules on every cycle. It checks that SCK stays low while chip select is released and that MOSI holds steady while SCK is high. It also checks that chip select is released only together with done, that done never lasts two cycles, and that an accepted start pulls chip select low one cycle later. Some behaviour only shows over a whole transaction, so it is left to the directed scenarios: the flag bit on each word, the placement of the dummy read clock, the byte order in both buffers, count clamping, zero-filling of unused read bytes and the dropped start while busy. The bench checks these against a model of the serial slave and the exact SCK pulse count.

// File: rtl/spi9_pkg.sv
`timescale 1ns/1ps
package spi9_pkg;

   localparam int WORD_W = 9;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LOW  = 3'd1,
      ST_HIGH = 3'd2,
      ST_HOLD = 3'd3,
      ST_DONE = 3'd4
   } spi9_state_t;

   typedef enum logic [1:0] {
      PH_CMD = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2
   } spi9_phase_t;

endpackage

// File: rtl/spi9_clkgen.sv
`timescale 1ns/1ps
module spi9_clkgen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         // Every cycle is a half period; no counter needed.
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick      = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end

         assign tick = run && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/spi9_shift.sv
`timescale 1ns/1ps
module spi9_shift
   import spi9_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              load_nine,
   input  logic              sample,
   input  logic              advance,
   input  logic              miso,
   output logic              mosi,
   output logic              last_bit,
   output logic [7:0]        rx_byte
);

   logic [WORD_W-1:0] tx_q;
   logic [7:0]        rx_q;
   logic [3:0]        left_q;

   // Transmit side: word is left-aligned so the MSB is always tx_q[8].
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         tx_q   <= load_nine ? load_word : {load_word[7:0], 1'b0};
         left_q <= load_nine ? 4'd9 : 4'd8;
      end else if (advance) begin
         tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
         left_q <= left_q - 4'd1;
      end
   end

   // Receive side: an 8-bit window keeps the newest eight samples,
   // which drops the leading bit of a 9-clock word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (sample) begin
         rx_q <= {rx_q[6:0], miso};
      end
   end

   assign mosi     = tx_q[WORD_W-1];
   assign last_bit = (left_q == 4'd1);
   assign rx_byte  = rx_q;

endmodule

// File: rtl/spi9_seq.sv
`timescale 1ns/1ps
module spi9_seq
   import spi9_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        cmd_byte,
   input  logic [CNT_W-1:0]  wr_cnt,
   input  logic [CNT_W-1:0]  rd_cnt,
   input  logic [7:0]        wr_byte,
   input  logic              tick,
   input  logic              last_bit,
   output logic              busy,
   output logic              done,
   output logic              run,
   output logic              cs_n,
   output logic              sck,
   output logic              ld,
   output logic [WORD_W-1:0] ld_word,
   output logic              ld_nine,
   output logic              sample,
   output logic              advance,
   output logic              rd_we,
   output logic [CNT_W-1:0]  idx,
   output logic [CNT_W-1:0]  wr_idx
);

   spi9_state_t      state_q;
   spi9_phase_t      phase_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] idx_p1;

   logic              have_next;
   spi9_phase_t       nxt_phase;
   logic [CNT_W-1:0]  nxt_idx;
   logic [WORD_W-1:0] nxt_word;
   logic              nxt_nine;
   logic              word_end;

   assign idx_p1   = idx_q + CNT_W'(1);
   assign word_end = (state_q == ST_HIGH) && tick && last_bit;

   // Choose the word that follows the one now finishing.
   always_comb begin
      have_next = 1'b0;
      nxt_phase = phase_q;
      nxt_idx   = idx_q;
      nxt_word  = '0;
      nxt_nine  = 1'b1;
      case (phase_q)
         PH_CMD: begin
            if (wr_cnt != '0) begin
               have_next = 1'b1;
               nxt_phase = PH_WR;
               nxt_idx   = '0;
               nxt_word  = {1'b1, wr_byte};
            end else if (rd_cnt != '0) begin
               have_next = 1'b1;
               nxt_phase = PH_RD;
               nxt_idx   = '0;
               nxt_nine  = (rd_cnt > CNT_W'(1));
            end
         end
         PH_WR: begin
            if (idx_p1 < wr_cnt) begin
               have_next = 1'b1;
               nxt_idx   = idx_p1;
               nxt_word  = {1'b1, wr_byte};
            end else if (rd_cnt != '0) begin
               have_next = 1'b1;
               nxt_phase = PH_RD;
               nxt_idx   = '0;
               nxt_nine  = (rd_cnt > CNT_W'(1));
            end
         end
         PH_RD: begin
            if (idx_p1 < rd_cnt) begin
               have_next = 1'b1;
               nxt_idx   = idx_p1;
               nxt_nine  = 1'b0;
            end
         end
         default: have_next = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_CMD;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_LOW;
                  phase_q <= PH_CMD;
                  idx_q   <= '0;
               end
            end
            ST_LOW: begin
               if (tick) state_q <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (!last_bit) begin
                     state_q <= ST_LOW;
                  end else if (have_next) begin
                     state_q <= ST_LOW;
                     phase_q <= nxt_phase;
                     idx_q   <= nxt_idx;
                  end else begin
                     state_q <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               if (tick) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);
   assign run     = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_HOLD);
   assign cs_n    = !run;
   assign sck     = (state_q == ST_HIGH);
   assign sample  = (state_q == ST_LOW) && tick;
   assign advance = (state_q == ST_HIGH) && tick && !last_bit;

   assign ld      = ((state_q == ST_IDLE) && start) || (word_end && have_next);
   assign ld_word = (state_q == ST_IDLE) ? {1'b0, cmd_byte} : nxt_word;
   assign ld_nine = (state_q == ST_IDLE) ? 1'b1 : nxt_nine;

   assign rd_we   = word_end && (phase_q == PH_RD);
   assign idx     = idx_q;
   assign wr_idx  = (phase_q == PH_CMD) ? '0 : idx_p1;

endmodule

// File: rtl/spi9_cmd_engine.sv
`timescale 1ns/1ps
module spi9_cmd_engine
   import spi9_pkg::*;
#(
   parameter  int HALF_DIV = 2,
   parameter  int MAX_WR   = 8,
   parameter  int MAX_RD   = 8,
   localparam int MAX_N    = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD,
   localparam int CNT_W    = $clog2(MAX_N + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [7:0]          cmd_byte,
   input  logic [CNT_W-1:0]    wr_count,
   input  logic [MAX_WR*8-1:0] wr_data,
   input  logic [CNT_W-1:0]    rd_count,
   output logic                busy,
   output logic                done,
   output logic [MAX_RD*8-1:0] rd_data,
   output logic                spi_cs_n,
   output logic                spi_sck,
   output logic                spi_mosi,
   input  logic                spi_miso
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi9_cmd_engine: HALF_DIV must be at least 1");
      end
      if (MAX_WR < 1 || MAX_RD < 1) begin : g_bad_depth
         $error("spi9_cmd_engine: MAX_WR and MAX_RD must be at least 1");
      end
   endgenerate

   logic              accept;
   logic [CNT_W-1:0]  wr_cnt_c, rd_cnt_c;
   logic [CNT_W-1:0]  wr_cnt_q, rd_cnt_q;
   logic [7:0]        wr_buf_q [MAX_WR];
   logic [7:0]        rd_buf_q [MAX_RD];
   logic [7:0]        wr_byte;
   logic [CNT_W-1:0]  wr_idx, rd_idx;

   logic              tick, run, last_bit;
   logic              ld, ld_nine, sample, advance, rd_we;
   logic [WORD_W-1:0] ld_word;
   logic [7:0]        rx_byte;

   assign accept   = start && !busy;
   assign wr_cnt_c = (wr_count > CNT_W'(MAX_WR)) ? CNT_W'(MAX_WR) : wr_count;
   assign rd_cnt_c = (rd_count > CNT_W'(MAX_RD)) ? CNT_W'(MAX_RD) : rd_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt_q <= '0;
         rd_cnt_q <= '0;
      end else if (accept) begin
         wr_cnt_q <= wr_cnt_c;
         rd_cnt_q <= rd_cnt_c;
      end
   end

   // Parameter bytes are captured at start so the client may change them.
   for (genvar i = 0; i < MAX_WR; i++) begin : g_wr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_buf_q[i] <= '0;
         end else if (accept) begin
            wr_buf_q[i] <= wr_data[i*8 +: 8];
         end
      end
   end

   always_comb begin
      wr_byte = '0;
      for (int i = 0; i < MAX_WR; i++) begin
         if (wr_idx == CNT_W'(i)) wr_byte = wr_buf_q[i];
      end
   end

   // Read buffer: cleared on every accepted start, filled per byte.
   for (genvar j = 0; j < MAX_RD; j++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_buf_q[j] <= '0;
         end else if (accept) begin
            rd_buf_q[j] <= '0;
         end else if (rd_we && (rd_idx == CNT_W'(j))) begin
            rd_buf_q[j] <= rx_byte;
         end
      end
      assign rd_data[j*8 +: 8] = rd_buf_q[j];
   end

   spi9_clkgen #(
      .HALF_DIV (HALF_DIV)
   ) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   spi9_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd_byte (cmd_byte),
      .wr_cnt   (wr_cnt_q),
      .rd_cnt   (rd_cnt_q),
      .wr_byte  (wr_byte),
      .tick     (tick),
      .last_bit (last_bit),
      .busy     (busy),
      .done     (done),
      .run      (run),
      .cs_n     (spi_cs_n),
      .sck      (spi_sck),
      .ld       (ld),
      .ld_word  (ld_word),
      .ld_nine  (ld_nine),
      .sample   (sample),
      .advance  (advance),
      .rd_we    (rd_we),
      .idx      (rd_idx),
      .wr_idx   (wr_idx)
   );

   spi9_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_word (ld_word),
      .load_nine (ld_nine),
      .sample    (sample),
      .advance   (advance),
      .miso      (spi_miso),
      .mosi      (spi_mosi),
      .last_bit  (last_bit),
      .rx_byte   (rx_byte)
   );

endmodule

// File: rtl/spi9_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi9_cmd_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);

   // R1
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R1
   mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> $stable(spi_mosi));

   // R8
   cs_release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> done);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> spi_cs_n);

   // R8
   start_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!spi_cs_n && busy));

endmodule

bind spi9_cmd_engine spi9_cmd_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .spi_cs_n (spi_cs_n),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi)
);

// File: tb/spi9_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi9_cmd_engine_tb;

   localparam int HALF_DIV = 2;
   localparam int MAX_WR   = 8;
   localparam int MAX_RD   = 8;
   localparam int CNT_W    = 4;
   localparam int PERIOD   = 8;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [7:0]          cmd_byte = '0;
   logic [CNT_W-1:0]    wr_count = '0;
   logic [MAX_WR*8-1:0] wr_data = '0;
   logic [CNT_W-1:0]    rd_count = '0;
   logic                busy, done;
   logic [MAX_RD*8-1:0] rd_data;
   logic                spi_cs_n, spi_sck, spi_mosi, spi_miso;

   int  checks = 0;
   int  fails  = 0;
   logic resp [256];
   logic got  [256];
   logic expb [256];
   int  rise_cnt = 0;
   int  miso_idx = 0;
   time t_rise = 0;
   time hi_len = 0;

   always #(PERIOD/2) clk = ~clk;

   spi9_cmd_engine #(
      .HALF_DIV (HALF_DIV),
      .MAX_WR   (MAX_WR),
      .MAX_RD   (MAX_RD)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd_byte (cmd_byte),
      .wr_count (wr_count),
      .wr_data  (wr_data),
      .rd_count (rd_count),
      .busy     (busy),
      .done     (done),
      .rd_data  (rd_data),
      .spi_cs_n (spi_cs_n),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso)
   );

   // Serial slave model: records MOSI at rises, presents MISO after falls.
   assign spi_miso = (miso_idx < 256) ? resp[miso_idx] : 1'b0;

   always @(posedge spi_sck) begin
      if (rise_cnt < 256) got[rise_cnt] = spi_mosi;
      rise_cnt = rise_cnt + 1;
      t_rise = $time;
   end

   always @(negedge spi_sck) begin
      miso_idx = rise_cnt;
      hi_len = $time - t_rise;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Full transaction with checks on bit stream, counts, buffer and pulses.
   task automatic run_txn(input logic [7:0] cmd, input int wcnt, input int rcnt,
                          input int seed, input bit poke_busy, input string cnt_req);
      int   w_eff, r_eff, n_exp, base, n, bad;
      logic [15:0] lf;
      logic [7:0]  eb;
      string req;
      w_eff = (wcnt > MAX_WR) ? MAX_WR : wcnt;
      r_eff = (rcnt > MAX_RD) ? MAX_RD : rcnt;
      lf = 16'(seed) | 16'h1;
      for (int i = 0; i < 256; i++) begin
         resp[i] = lf[0];
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      end
      for (int i = 0; i < MAX_WR; i++) wr_data[i*8 +: 8] = 8'((seed * 17) + (i * 29) + 1);
      rise_cnt = 0;
      miso_idx = 0;
      @(negedge clk);
      cmd_byte = cmd;
      wr_count = CNT_W'(wcnt);
      rd_count = CNT_W'(rcnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cmd_byte = ~cmd;
      if (poke_busy) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         cmd_byte = 8'hFF;
         wr_count = '0;
         rd_count = '0;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(done == 1'b1, "R8", "done seen", done, 1);
      check(spi_cs_n == 1'b1, "R8", "cs high with done", spi_cs_n, 1);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R8", "done one cycle, idle after",
            {done, busy}, 0);
      // Expected bit stream
      n_exp = 9 + 9 * w_eff + ((r_eff == 0) ? 0 : (r_eff == 1) ? 8 : 9 + 8 * (r_eff - 1));
      check(rise_cnt == n_exp, cnt_req, "sck pulse count", rise_cnt, n_exp);
      expb[0] = 1'b0;
      for (int b = 0; b < 8; b++) expb[1 + b] = cmd[7 - b];
      for (int p = 0; p < w_eff; p++) begin
         eb = wr_data[p*8 +: 8];
         expb[9 + 9*p] = 1'b1;
         for (int b = 0; b < 8; b++) expb[10 + 9*p + b] = eb[7 - b];
      end
      for (int k = 9 + 9*w_eff; k < n_exp; k++) expb[k] = 1'b0;
      bad = -1;
      for (int k = 0; k < n_exp && k < 256; k++) begin
         if (bad < 0 && got[k] !== expb[k]) bad = k;
      end
      req = (bad < 9) ? "R3" : (bad < 9 + 9*w_eff) ? "R4" : "R6";
      check(bad < 0, req, "mosi bit stream first mismatch index", bad, -1);
      // Expected read bytes
      base = 9 + 9 * w_eff;
      for (int j = 0; j < MAX_RD; j++) begin
         eb = '0;
         if (j < r_eff) begin
            for (int b = 0; b < 8; b++) begin
               if (r_eff == 1)  eb[7-b] = resp[base + b];
               else if (j == 0) eb[7-b] = resp[base + 1 + b];
               else             eb[7-b] = resp[base + 9 + 8*(j-1) + b];
            end
         end
         req = (j >= r_eff) ? "R11" : (r_eff == 1) ? "R5" : "R6";
         check(rd_data[j*8 +: 8] == eb, req, $sformatf("read byte %0d", j),
               rd_data[j*8 +: 8], eb);
      end
      check(hi_len == time'(HALF_DIV * PERIOD), "R2", "sck high width ns",
            hi_len, HALF_DIV * PERIOD);
      if (poke_busy) begin
         repeat (4 * HALF_DIV + 4) @(negedge clk);
         check(spi_cs_n == 1'b1 && busy == 1'b0 && rise_cnt == n_exp, "R10",
               "no transaction from start while busy", rise_cnt, n_exp);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "idle pins after reset",
            {spi_cs_n, spi_sck}, 2'b10);
      check(busy == 1'b0 && done == 1'b0, "R8", "idle status after reset",
            {busy, done}, 0);
      check(rd_data == '0, "R11", "read buffer after reset", rd_data, 0);
   endtask

   task automatic t_cmd_only;     run_txn(8'h29, 0, 0, 11, 1'b0, "R7"); endtask
   task automatic t_params;       run_txn(8'h3A, 2, 0, 23, 1'b0, "R7"); endtask
   task automatic t_single_read;  run_txn(8'h0A, 0, 1, 37, 1'b0, "R7"); endtask
   task automatic t_multi_read;   run_txn(8'h04, 0, 3, 41, 1'b0, "R7"); endtask
   task automatic t_params_read;  run_txn(8'hC2, 3, 8, 59, 1'b0, "R7"); endtask
   task automatic t_clamp;        run_txn(8'hB5, 9, 12, 71, 1'b0, "R9"); endtask
   task automatic t_partial_fill; run_txn(8'h0F, 1, 2, 83, 1'b0, "R7"); endtask
   task automatic t_busy_start;   run_txn(8'h11, 1, 1, 97, 1'b1, "R7"); endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cmd_only();
      t_params();
      t_single_read();
      t_multi_read();
      t_params_read();
      t_clamp();
      t_partial_fill();
      t_busy_start();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * PERIOD);
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule